// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a logical address, made of a 7-bit segment number and a 16-bit offset, into a 24-bit physical address. It holds a table of segment descriptors. Each descriptor carries a valid flag, an 8-bit physical base and an 8-bit length limit. On each accepted request the base becomes the upper eight address bits and the offset passes through unchanged as the lower sixteen. Before any address is produced, the offset is compared against the segment length. An offset beyond the length, or a hit on a descriptor that is not valid, raises a fault instead of an address.

One unit serves half of the 128-segment logical space, and a configuration input chooses which half. Two units with opposite settings share the request bus and together cover every segment number. A unit stays silent for segment numbers outside its half. Descriptors are loaded through a single-cycle write port that takes a local table index. The result of a request is registered and appears one clock after the request strobe.

Top module: `seg_xlate_unit`

## Requirements
- R1: After synchronous reset, xl_valid, xl_fault and xl_addr are 0 and every descriptor is invalid, so any served request faults until a descriptor is written.
- R2: A request strobed at clock edge N produces its result after edge N+1 only. A cycle with no request leaves xl_valid and xl_fault at 0 on the next cycle.
- R3: A successful translation drives xl_addr = {base[7:0], offset[15:0]}, with the base in bits 23:16.
- R4: The length field counts 256-byte blocks minus one. An offset is in range when offset[15:8] <= length, so length 255 spans the whole 64 kB. An offset out of range sets xl_fault and leaves xl_valid at 0.
- R5: A request that hits a descriptor whose valid flag is 0 sets xl_fault and leaves xl_valid at 0.
- R6: xl_valid and xl_fault are never both 1, and xl_addr is 0 whenever xl_valid is 0.
- R7: The unit serves a request only when req_seg[6] equals half_sel. It then uses req_seg[5:0] as the table index. For any other segment number, xl_valid and xl_fault stay 0.
- R8: A descriptor write presented at edge N is seen by requests at edge N+1 and later. A request at the same edge N as the write sees the old descriptor.
- R9: Writing a descriptor with wr_vld = 0 makes later requests to that segment fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_sel | input | 1 | Selects the served half: 0 for segments 0 to 63, 1 for segments 64 to 127 |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 7 | Logical segment number |
| req_off | input | 16 | Logical offset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 6 | Local descriptor index to write |
| wr_vld | input | 1 | Valid flag written to the descriptor |
| wr_base | input | 8 | Physical base written to the descriptor |
| wr_len | input | 8 | Length limit written to the descriptor, in 256-byte blocks minus one |
| xl_valid | output | 1 | Physical address valid, one cycle after the request |
| xl_addr | output | 24 | Physical address |
| xl_fault | output | 1 | Translation fault, one cycle after the request |

## Verification
The bench drives inputs on the falling edge. Each request is held for exactly one rising edge, and the outputs are sampled on the following falling edge, one register stage after the request. The bench also samples the idle cycle that follows every request, which shows that a result lasts only one cycle and that a cycle with no request yields nothing.

Write timing is checked by driving a write and a request to the same index in the same cycle, where the old descriptor must still apply. A request in the next cycle must then see the new descriptor. The bench predicts every expected result from its own copy of the descriptors, built from the requirements alone.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEG_W  = 7;
    localparam int OFF_W  = 16;
    localparam int BASE_W = 8;
    localparam int LEN_W  = 8;
    localparam int IDX_W  = SEG_W - 1;
    localparam int PHYS_W = BASE_W + OFF_W;
    localparam int NUM_DESC = 1 << IDX_W;
    localparam int BLK_W  = OFF_W - LEN_W;

    typedef struct packed {
        logic              vld;
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } seg_desc_t;

    typedef enum logic [1:0] {
        XL_PASS    = 2'd0,
        XL_NODESC  = 2'd1,
        XL_OVERRUN = 2'd2
    } xl_verdict_e;

    typedef struct packed {
        logic              vld;
        logic              fault;
        logic [PHYS_W-1:0] addr;
    } xl_resp_t;

    function automatic logic seg_is_mine(input logic [SEG_W-1:0] seg, input logic half);
        return seg[SEG_W-1] == half;
    endfunction

    function automatic logic [PHYS_W-1:0] compose_addr(input logic [BASE_W-1:0] base,
                                                       input logic [OFF_W-1:0]  off);
        return {base, off};
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = NUM_DESC,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic [AW-1:0] wr_idx,
    input  seg_desc_t wr_desc,
    input  logic [AW-1:0] rd_idx,
    output seg_desc_t rd_desc
);

    seg_desc_t entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[g] <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                entry[g] <= wr_desc;
            end
        end
    end

    assign rd_desc = entry[rd_idx];

    // R8: a written descriptor is in place one cycle after the strobe
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (entry[$past(wr_idx)] == $past(wr_desc)));

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_xlate_pkg::*;
(
    input  seg_desc_t         desc,
    input  logic [OFF_W-1:0]  off,
    output xl_verdict_e       verdict
);

    logic [BLK_W-1:0] blk;
    assign blk = off[OFF_W-1:LEN_W];

    always_comb begin
        if (!desc.vld) begin
            verdict = XL_NODESC;
        end else if (blk > desc.len) begin
            verdict = XL_OVERRUN;
        end else begin
            verdict = XL_PASS;
        end
    end

    // R4: a full-length segment never overruns
    always_comb begin
        if (desc.vld && desc.len == '1) begin
            assert_full_len_pass_R4: assert (verdict == XL_PASS);
        end
    end

endmodule

// File: rtl/seg_xlate_stage.sv
module seg_xlate_stage
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  xl_verdict_e       verdict,
    input  logic [BASE_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output xl_resp_t          resp
);

    xl_resp_t nxt;

    always_comb begin
        nxt = '0;
        if (accept) begin
            if (verdict == XL_PASS) begin
                nxt.vld  = 1'b1;
                nxt.addr = compose_addr(base, off);
            end else begin
                nxt.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp <= '0;
        end else begin
            resp <= nxt;
        end
    end

    // R6: address and fault are mutually exclusive
    assert_valid_fault_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(resp.vld && resp.fault));

    // R6: address bus parks at zero without a valid result
    assert_addr_parked_R6: assert property (@(posedge clk) disable iff (rst)
        !resp.vld |-> (resp.addr == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              half_sel,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_vld,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LEN_W-1:0]  wr_len,
    output logic              xl_valid,
    output logic [PHYS_W-1:0] xl_addr,
    output logic              xl_fault
);

    seg_desc_t   wr_desc;
    seg_desc_t   rd_desc;
    xl_verdict_e verdict;
    xl_resp_t    resp;
    logic        mine;
    logic        accept;

    assign wr_desc = '{vld: wr_vld, base: wr_base, len: wr_len};
    assign mine    = seg_is_mine(req_seg, half_sel);
    assign accept  = req_valid && mine;

    seg_desc_table #(.DEPTH(NUM_DESC)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_desc (wr_desc),
        .rd_idx  (req_seg[IDX_W-1:0]),
        .rd_desc (rd_desc)
    );

    seg_limit_check u_limit (
        .desc    (rd_desc),
        .off     (req_off),
        .verdict (verdict)
    );

    seg_xlate_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .verdict (verdict),
        .base    (rd_desc.base),
        .off     (req_off),
        .resp    (resp)
    );

    assign xl_valid = resp.vld;
    assign xl_fault = resp.fault;
    assign xl_addr  = resp.addr;

    // R7: foreign segment numbers produce no response
    assert_foreign_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_seg[SEG_W-1] != half_sel)) |=> (!xl_valid && !xl_fault));

    // R2: no request, no response
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!xl_valid && !xl_fault));

    // R3: offset bits pass through unchanged
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!xl_valid || (xl_addr[OFF_W-1:0] == $past(req_off))));

    // R4: overrun of the length limit faults
    assert_overrun_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && rd_desc.vld && (req_off[OFF_W-1:LEN_W] > rd_desc.len)) |=> xl_fault);

    // R5: invalid descriptor faults
    assert_nodesc_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !rd_desc.vld) |=> (xl_fault && !xl_valid));

endmodule

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        half_sel;
    logic        req_valid;
    logic [6:0]  req_seg;
    logic [15:0] req_off;
    logic        wr_en;
    logic [5:0]  wr_idx;
    logic        wr_vld;
    logic [7:0]  wr_base;
    logic [7:0]  wr_len;
    logic        xl_valid;
    logic [23:0] xl_addr;
    logic        xl_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic        m_vld  [64];
    logic [7:0]  m_base [64];
    logic [7:0]  m_len  [64];

    always #4 clk = ~clk;

    seg_xlate_unit u_dut (
        .clk(clk), .rst(rst), .half_sel(half_sel),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
        .wr_base(wr_base), .wr_len(wr_len),
        .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_fault(xl_fault)
    );

    task automatic check(input string tag, input logic v, input logic [23:0] a,
                         input logic f, input logic ev, input logic [23:0] ea, input logic ef);
        n_checks++;
        if (v !== ev || a !== ea || f !== ef) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b addr=%06h fault=%0b, expected valid=%0b addr=%06h fault=%0b",
                     tag, v, a, f, ev, ea, ef);
        end
    endtask

    task automatic predict(input logic [6:0] seg, input logic [15:0] off,
                           output logic ev, output logic [23:0] ea, output logic ef);
        int i;
        i = int'(seg[5:0]);
        ev = 1'b0; ea = '0; ef = 1'b0;
        if (seg[6] == half_sel) begin
            if (m_vld[i] && off[15:8] <= m_len[i]) begin
                ev = 1'b1;
                ea = {m_base[i], off};
            end else begin
                ef = 1'b1;
            end
        end
    endtask

    task automatic do_write(input logic [5:0] idx, input logic v, input logic [7:0] b, input logic [7:0] l);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vld = v; wr_base = b; wr_len = l;
        @(negedge clk);
        wr_en = 1'b0;
        m_vld[idx] = v; m_base[idx] = b; m_len[idx] = l;
    endtask

    task automatic do_req(input string tag, input logic [6:0] seg, input logic [15:0] off);
        logic ev, ef;
        logic [23:0] ea;
        predict(seg, off, ev, ea, ef);
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_off = off;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, xl_valid, xl_addr, xl_fault, ev, ea, ef);
        @(negedge clk);
        check({tag, " R2 idle after"}, xl_valid, xl_addr, xl_fault, 1'b0, 24'h0, 1'b0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset outputs", xl_valid, xl_addr, xl_fault, 1'b0, 24'h0, 1'b0);
        do_req("R1 R5 empty table faults", 7'd0, 16'h0000);
        do_req("R1 R5 empty table faults top", 7'd63, 16'h1234);
    endtask

    task automatic t_basic;
        do_write(6'd5, 1'b1, 8'hA3, 8'hFF);
        do_req("R3 R4 full segment top byte", 7'd5, 16'hFFFF);
        do_req("R3 offset zero", 7'd5, 16'h0000);
        do_write(6'd63, 1'b1, 8'h5C, 8'hFF);
        do_req("R3 last index", 7'd63, 16'h8421);
    endtask

    task automatic t_limit;
        do_write(6'd9, 1'b1, 8'h12, 8'h10);
        do_req("R4 last in-range byte", 7'd9, 16'h10FF);
        do_req("R4 first out-of-range byte", 7'd9, 16'h1100);
        do_req("R4 far beyond limit", 7'd9, 16'hFFFF);
        do_write(6'd10, 1'b1, 8'h34, 8'h00);
        do_req("R4 length zero in range", 7'd10, 16'h00FF);
        do_req("R4 length zero overrun", 7'd10, 16'h0100);
    endtask

    task automatic t_half;
        do_req("R7 upper half ignored by lower unit", 7'h45, 16'h0010);
        half_sel = 1'b1;
        do_req("R7 index reuse in upper half", 7'h45, 16'h0010);
        do_req("R7 lower half ignored by upper unit", 7'h05, 16'h0010);
        do_req("R7 R5 upper half empty slot", 7'h7F & 7'h4B, 16'h0000);
        half_sel = 1'b0;
    endtask

    task automatic t_write_timing;
        logic ev, ef;
        logic [23:0] ea;
        predict(7'd20, 16'h0400, ev, ea, ef);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd20; wr_vld = 1'b1; wr_base = 8'hC7; wr_len = 8'h07;
        req_valid = 1'b1; req_seg = 7'd20; req_off = 16'h0400;
        @(negedge clk);
        wr_en = 1'b0;
        m_vld[20] = 1'b1; m_base[20] = 8'hC7; m_len[20] = 8'h07;
        check("R8 same-cycle request sees old", xl_valid, xl_addr, xl_fault, ev, ea, ef);
        predict(7'd20, 16'h0400, ev, ea, ef);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 next-cycle request sees new", xl_valid, xl_addr, xl_fault, ev, ea, ef);
        @(negedge clk);
        check("R8 R2 idle after", xl_valid, xl_addr, xl_fault, 1'b0, 24'h0, 1'b0);
    endtask

    task automatic t_invalidate;
        do_write(6'd5, 1'b0, 8'hA3, 8'hFF);
        do_req("R9 invalidated segment faults", 7'd5, 16'h0000);
    endtask

    task automatic t_back_to_back;
        logic ev0, ef0, ev1, ef1;
        logic [23:0] ea0, ea1;
        for (int k = 0; k < 8; k++) begin
            do_write(6'(k * 7 + 1), 1'b1, 8'(8'h20 + k), 8'(k * 32));
        end
        predict(7'd8, 16'h2000, ev0, ea0, ef0);
        predict(7'd15, 16'h6000, ev1, ea1, ef1);
        @(negedge clk);
        req_valid = 1'b1; req_seg = 7'd8; req_off = 16'h2000;
        @(negedge clk);
        req_seg = 7'd15; req_off = 16'h6000;
        check("R2 back-to-back first", xl_valid, xl_addr, xl_fault, ev0, ea0, ef0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 back-to-back second", xl_valid, xl_addr, xl_fault, ev1, ea1, ef1);
        for (int k = 0; k < 8; k++) begin
            do_req("R3 R4 sweep", 7'(k * 7 + 1), 16'(k * 16'h1F00));
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_vld[i] = 1'b0; m_base[i] = '0; m_len[i] = '0;
        end
        rst = 1'b1; half_sel = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0;
        wr_en = 1'b0; wr_idx = '0; wr_vld = 1'b0; wr_base = '0; wr_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_limit();
        t_half();
        t_write_timing();
        t_invalidate();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule